// File: doc/BRIEF.md
# Flash Write-Protection Guard

This block keeps the protection field and the lock flag of a serial NOR flash status register. For every program or erase request it decides whether the operation may touch the array. The array is 512 KB in size, byte addresses 00000h to 7FFFFh. It is split into eight 64 KB blocks, and address bits [18:16] give the block index. A three-bit protection level names a region at the top of the array. Each level doubles the region in power-of-two steps. Any level with its top bit set covers the whole array. A request whose target lies inside the region is refused.

A lock flag can freeze the protection field and the flag itself. The lock works only while the active-low write-protect pin is held low. With the pin high, the lock is ignored. A command decoder in front of this block sends status-register writes and operation requests. One clock after each request, the guard returns a one-cycle grant or deny pulse.

Top module: `fwp_guard`

## Requirements
- R1: A synchronous reset sets the protection level `bp_q` to 3'b111 and `lock_q` to 0. `grant` and `deny` are low during reset and in the first cycle after it.
- R2: Level 3'b000 protects nothing. 3'b001 protects block 7 (70000h–7FFFFh). 3'b010 protects blocks 6–7. 3'b011 protects blocks 4–7. Every level with bit 2 set protects all of blocks 0–7.
- R3: For a page program (`req_op`=0), a sector erase (`req_op`=1) or a block erase (`req_op`=2), the request is denied when block `req_addr[18:16]` is protected. It is granted otherwise.
- R4: A chip erase (`req_op`=3) is granted only when `bp_q` is 3'b000, whatever the value of `req_addr`.
- R5: A request sampled at a rising edge gives exactly one of `grant` or `deny`, high for the single following cycle. A cycle with no request gives neither.
- R6: While `wp_n` is high, a status write (`sr_wr`) loads `sr_bp` into `bp_q` and `sr_lock` into `lock_q`, whatever the value of `lock_q`.
- R7: While `wp_n` is low and `lock_q` is 1, a status write leaves `bp_q` and `lock_q` unchanged.
- R8: While `wp_n` is low and `lock_q` is 0, a status write loads both fields. It can also set the lock.
- R9: A request in the same cycle as a status write is judged against the protection level in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wp_n | input | 1 | Write-protect pin, active low |
| sr_wr | input | 1 | Status-register write strobe |
| sr_bp | input | 3 | New protection level |
| sr_lock | input | 1 | New lock flag |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | 19 | Target byte address |
| bp_q | output | 3 | Current protection level |
| lock_q | output | 1 | Current lock flag |
| grant | output | 1 | One-cycle pulse: request may proceed |
| deny | output | 1 | One-cycle pulse: request refused |

## Verification
The first address of each protected region and the address just below it are tried at every level. A wrong comparison edge or a wrong region size shows up there as a single flipped decision. Chip erase is tried at level zero and at nonzero levels, which separates it from the address rule. Status writes are tried with every combination of pin and lock. A write in the same cycle as a request shows whether the old or the new level was applied. A long random mix of writes and requests then covers the interaction between the two.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SECT   = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_CHIP   = 2'd3
  } op_e;
endpackage

// File: rtl/fwp_status_reg.sv
module fwp_status_reg #(
  parameter int BP_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wp_n,
  input  logic            sr_wr,
  input  logic [BP_W-1:0] sr_bp,
  input  logic            sr_lock,
  output logic [BP_W-1:0] bp_q,
  output logic            lock_q
);
  logic wr_ok;
  // the lock only freezes the field while the pin is held low
  assign wr_ok = sr_wr && (wp_n || !lock_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q   <= '1;
      lock_q <= 1'b0;
    end else if (wr_ok) begin
      bp_q   <= sr_bp;
      lock_q <= sr_lock;
    end
  end
endmodule

// File: rtl/fwp_range_decode.sv
module fwp_range_decode #(
  parameter int BP_W  = 3,
  parameter int BLK_W = 3
) (
  input  logic [BP_W-1:0]  bp,
  output logic [BLK_W-1:0] lowest_blk,
  output logic             prot_none
);
  localparam int NBLK = 1 << BLK_W;

  int span;
  int low_i;

  always_comb begin
    prot_none = (bp == '0);
    span      = 0;
    low_i     = 0;
    if (!prot_none && !bp[BP_W-1]) begin
      span  = 1 << (int'(bp) - 1);
      low_i = (span >= NBLK) ? 0 : NBLK - span;
    end
    lowest_blk = low_i[BLK_W-1:0];
  end
endmodule

// File: rtl/fwp_check.sv
module fwp_check
  import fwp_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BLK_W-1:0]  lowest_blk,
  input  logic              prot_none,
  output logic              grant,
  output logic              deny
);
  logic [BLK_W-1:0] blk;
  logic             ok;
  op_e              op;

  assign blk = req_addr[ADDR_W-1 -: BLK_W];
  assign op  = op_e'(req_op);

  always_comb begin
    if (op == OP_CHIP) ok = prot_none;
    else               ok = prot_none || (blk < lowest_blk);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= req_valid && ok;
      deny  <= req_valid && !ok;
    end
  end
endmodule

// File: rtl/fwp_guard.sv
module fwp_guard #(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 3,
  parameter int BP_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic              sr_wr,
  input  logic [BP_W-1:0]   sr_bp,
  input  logic              sr_lock,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [BP_W-1:0]   bp_q,
  output logic              lock_q,
  output logic              grant,
  output logic              deny
);
  logic [BLK_W-1:0] lowest_blk;
  logic             prot_none;

  fwp_status_reg #(.BP_W(BP_W)) sr_i (
    .clk(clk), .rst(rst), .wp_n(wp_n), .sr_wr(sr_wr), .sr_bp(sr_bp),
    .sr_lock(sr_lock), .bp_q(bp_q), .lock_q(lock_q)
  );

  // decode uses the registered level, so a same-cycle write is not yet seen
  fwp_range_decode #(.BP_W(BP_W), .BLK_W(BLK_W)) dec_i (
    .bp(bp_q), .lowest_blk(lowest_blk), .prot_none(prot_none)
  );

  fwp_check #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .lowest_blk(lowest_blk), .prot_none(prot_none),
    .grant(grant), .deny(deny)
  );
endmodule

// File: rtl/fwp_guard_chk.sv
module fwp_guard_chk #(
  parameter int BP_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            wp_n,
  input logic            sr_wr,
  input logic [BP_W-1:0] sr_bp,
  input logic            sr_lock,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic [BP_W-1:0] bp_q,
  input logic            lock_q,
  input logic            grant,
  input logic            deny
);
  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    (past_valid && $past(rst)) |-> (bp_q == '1 && !lock_q && !grant && !deny));

  a_r5_one_result: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant, deny}));

  a_r5_answer: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (grant || deny));

  a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!grant && !deny));

  a_r4_chip_nonzero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd3 && bp_q != '0) |=> deny);

  a_r7_locked: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && lock_q) |=> ($stable(bp_q) && $stable(lock_q)));

  a_r6_write: assert property (@(posedge clk) disable iff (rst)
    (sr_wr && (wp_n || !lock_q)) |=> (bp_q == $past(sr_bp) && lock_q == $past(sr_lock)));
endmodule

bind fwp_guard fwp_guard_chk #(.BP_W(BP_W)) chk_b (
  .clk(clk), .rst(rst), .wp_n(wp_n), .sr_wr(sr_wr), .sr_bp(sr_bp),
  .sr_lock(sr_lock), .req_valid(req_valid), .req_op(req_op),
  .bp_q(bp_q), .lock_q(lock_q), .grant(grant), .deny(deny)
);

// File: tb/fwp_guard_tb.sv
module fwp_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wp_n = 1'b1;
  logic        sr_wr = 1'b0;
  logic [2:0]  sr_bp = '0;
  logic        sr_lock = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [18:0] req_addr = '0;
  logic [2:0]  bp_q;
  logic        lock_q, grant, deny;

  int checks = 0;
  int failures = 0;
  logic [2:0] m_bp = 3'b111;
  logic       m_lock = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  fwp_guard dut_i (
    .clk(clk), .rst(rst), .wp_n(wp_n), .sr_wr(sr_wr), .sr_bp(sr_bp),
    .sr_lock(sr_lock), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .bp_q(bp_q), .lock_q(lock_q),
    .grant(grant), .deny(deny)
  );

  function automatic bit exp_ok(logic [2:0] bp, logic [1:0] op, logic [18:0] a);
    int low;
    if (op == 2'd3) return (bp == 3'b000);
    case (bp)
      3'b000: low = 8;
      3'b001: low = 7;
      3'b010: low = 6;
      3'b011: low = 4;
      default: low = 0;
    endcase
    return int'(a[18:16]) < low;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; inputs apply to the next rising edge
  task automatic step(string tag, bit wp, bit wr, logic [2:0] nbp, bit nlk,
                      bit rv, logic [1:0] op, logic [18:0] a);
    logic [1:0] exp_gd;
    wp_n = wp; sr_wr = wr; sr_bp = nbp; sr_lock = nlk;
    req_valid = rv; req_op = op; req_addr = a;
    exp_gd = rv ? (exp_ok(m_bp, op, a) ? 2'b10 : 2'b01) : 2'b00;
    if (wr && (wp || !m_lock)) begin
      m_bp = nbp; m_lock = nlk;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " R5 grant/deny"}, {30'd0, grant, deny}, {30'd0, exp_gd});
    check({tag, " level"}, {29'd0, bp_q}, {29'd0, m_bp});
    check({tag, " lock"}, {31'd0, lock_q}, {31'd0, m_lock});
    sr_wr = 1'b0; req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset level", {29'd0, bp_q}, 32'd7);
    check("R1 reset lock", {31'd0, lock_q}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset outputs", {29'd0, bp_q, grant, deny, lock_q}, {29'd0, 3'b111, 3'b000});

    step("R2 all protected prog", 1, 0, 0, 0, 1, 2'd0, 19'h00000);
    step("R4 chip at 111", 1, 0, 0, 0, 1, 2'd3, 19'h00000);
    step("R6 clear level", 1, 1, 3'b000, 0, 0, 2'd0, 19'h0);
    step("R2 none prog top", 1, 0, 0, 0, 1, 2'd0, 19'h7FFFF);
    step("R4 chip at 000", 1, 0, 0, 0, 1, 2'd3, 19'h12345);
    for (int lv = 1; lv <= 3; lv++) begin
      logic [18:0] edge_a;
      edge_a = (lv == 1) ? 19'h70000 : (lv == 2) ? 19'h60000 : 19'h40000;
      step("R6 set level", 1, 1, 3'(lv), 0, 0, 2'd0, 19'h0);
      step("R3 below region", 1, 0, 0, 0, 1, 2'd1, edge_a - 19'd1);
      step("R3 region start", 1, 0, 0, 0, 1, 2'd2, edge_a);
      step("R2 region top", 1, 0, 0, 0, 1, 2'd0, 19'h7FFFF);
      step("R4 chip nonzero", 1, 0, 0, 0, 1, 2'd3, 19'h0);
    end
    step("R6 level 101", 1, 1, 3'b101, 0, 0, 2'd0, 19'h0);
    step("R2 bit2 all blocks", 1, 0, 0, 0, 1, 2'd0, 19'h00000);
    step("R8 pin low unlocked write", 0, 1, 3'b011, 1, 0, 2'd0, 19'h0);
    check("R8 level loaded", {29'd0, bp_q}, 32'd3);
    step("R7 locked write ignored", 0, 1, 3'b000, 0, 0, 2'd0, 19'h0);
    check("R7 level kept", {28'd0, bp_q, lock_q}, {28'd0, 3'b011, 1'b1});
    step("R7 locked request", 0, 0, 0, 0, 1, 2'd0, 19'h3FFFF);
    step("R6 pin high overrides lock", 1, 1, 3'b000, 1, 0, 2'd0, 19'h0);
    check("R6 level cleared", {29'd0, bp_q}, 32'd0);
    step("R9 write with request", 1, 1, 3'b111, 0, 1, 2'd0, 19'h00000);
    check("R9 old level used", {30'd0, grant, deny}, 32'd2);
    step("R9 new level next", 1, 0, 0, 0, 1, 2'd0, 19'h00000);
    step("R5 idle", 1, 0, 0, 0, 0, 2'd0, 19'h0);

    for (int i = 0; i < 400; i++) begin
      bit wp, wr, lk, rv;
      wp = ($urandom % 3) != 0;
      wr = ($urandom % 4) == 0;
      lk = ($urandom % 3) == 0;
      rv = ($urandom % 4) != 0;
      step("R3 random", wp, wr, 3'($urandom % 8), lk, rv,
           2'($urandom % 4), 19'($urandom % 32'h80000));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule